// File: doc/BRIEF.md
# Byte-Mode Operand Address Generator

This block turns a memory-reference instruction word into the location of a byte operand when the processor works on bytes rather than words. It reads the 2-bit mode field, the indirect tag and the 8-bit displacement of the instruction. It combines them with the program counter (a word address) and the index register (a byte address). The result is a word address plus a byte select. Byte select 0 names the left (upper) byte of the word and 1 names the right (lower) byte.

Direct forms finish in one clock cycle. In the indirect forms the block first computes the word address of a 16-bit pointer and fetches that pointer through a simple read port. It then uses the pointer as a byte address, adding the index register in one of the modes. Only one level of indirection exists. The fetched pointer is always final, whatever its contents.

All address sums wrap modulo 2^16. A byte address is split into a word address, which is the byte address shifted right by one, and a byte select, which is its bit 0. Word addresses leave the block as the low 15 bits, which covers a 32K-word (64K-byte) space.

Top module: `bmode_ea_gen`

## Requirements
- R1: After reset, `done` and `rd_req` are 0.
- R2: Direct, mode 00 (instr[10:9]=00, instr[8]=0): the byte address is D = instr[7:0] zero-extended. `ea_word` = D>>1 and `ea_bsel` = D[0], so the word is always below 128. `done` pulses for exactly the cycle after the clock edge that samples `start`.
- R3: Direct, mode 01 or 11: `ea_word` = P+1+D. `ea_bsel` is 0 for mode 01 (left byte) and 1 for mode 11 (right byte).
- R4: Direct, mode 10: the byte address is X+D, split into `ea_word` and `ea_bsel`.
- R5: Indirect (instr[8]=1): in the cycle after `start`, `rd_req` rises and `done` stays 0. `rd_addr` is D for modes 00 and 10, P+1+D for mode 01 and P−D for mode 11. Both are held unchanged until `rd_valid` is seen.
- R6: Indirect result: on the cycle after `rd_valid` is sampled, `done` pulses. The byte address is the read data for modes 00, 01 and 11, and the read data plus X for mode 10.
- R7: Only one pointer is read per instruction. After `rd_valid`, `rd_req` falls together with the `done` pulse, whatever the pointer holds.
- R8: `start` has no effect while a pointer read is pending. `rd_addr` stays the same and no `done` appears.
- R9: All sums wrap modulo 2^16, and word addresses are the low 15 bits of the sum.
- R10: The opcode bits instr[15:11] have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin address generation for `instr` |
| instr | input | 16 | Instruction word |
| pc | input | 16 | Program counter (word address) |
| xr | input | 16 | Index register (byte address) |
| rd_data | input | 16 | Pointer word returned by memory |
| rd_valid | input | 1 | `rd_data` is valid this cycle |
| rd_req | output | 1 | Pointer read request, held until `rd_valid` |
| rd_addr | output | 15 | Word address of the pointer |
| ea_word | output | 15 | Operand word address |
| ea_bsel | output | 1 | Operand byte select (0 left, 1 right) |
| done | output | 1 | One-cycle strobe: `ea_word`/`ea_bsel` valid |

## Verification
The assertions check the handshake on every cycle: a direct start gives a `done` one cycle later, an indirect start raises a request, the request and its address hold while memory is slow, a single `rd_valid` ends the request, a busy `start` produces nothing, and page-zero results stay below word 128. The actual address values can only be shown by the bench's sweeps. These cover every mode and many displacement, counter and index values, with wrap-around cases and several memory latencies. The expected addresses are computed arithmetically from the mode rules.

// File: rtl/bea_pkg.sv
package bea_pkg;
   typedef enum logic [1:0] {
      MD_PAGE0 = 2'b00,
      MD_FWD_L = 2'b01,
      MD_INDEX = 2'b10,
      MD_FWD_R = 2'b11
   } bmode_e;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_WAIT = 1'b1
   } seq_e;
endpackage

// File: rtl/bea_calc.sv
module bea_calc
   import bea_pkg::*;
#(
   parameter int AW = 16,
   parameter int DW = 8
) (
   input  bmode_e         mode,
   input  logic [DW-1:0]  disp,
   input  logic [AW-1:0]  pc,
   input  logic [AW-1:0]  xr,
   output logic [AW-2:0]  dir_word,
   output logic           dir_bsel,
   output logic [AW-2:0]  ptr_word
);
   localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

   generate
      if (AW < 9 || DW >= AW) begin : g_bad_cfg
         $error("bea_calc: AW must be at least 9 and larger than DW");
      end
   endgenerate

   logic [AW-1:0] d_ext;
   logic [AW-1:0] fwd_w;
   logic [AW-1:0] back_w;
   logic [AW-1:0] idx_b;

   assign d_ext  = {{(AW-DW){1'b0}}, disp};
   assign fwd_w  = pc + ONE + d_ext;
   assign back_w = pc - d_ext;
   assign idx_b  = xr + d_ext;

   // direct result
   always_comb begin
      case (mode)
         MD_PAGE0: begin
            dir_word = d_ext[AW-1:1];
            dir_bsel = d_ext[0];
         end
         MD_FWD_L: begin
            dir_word = fwd_w[AW-2:0];
            dir_bsel = 1'b0;
         end
         MD_FWD_R: begin
            dir_word = fwd_w[AW-2:0];
            dir_bsel = 1'b1;
         end
         default: begin
            dir_word = idx_b[AW-1:1];
            dir_bsel = idx_b[0];
         end
      endcase
   end

   // pointer location for indirect forms
   always_comb begin
      case (mode)
         MD_FWD_L: ptr_word = fwd_w[AW-2:0];
         MD_FWD_R: ptr_word = back_w[AW-2:0];
         default:  ptr_word = d_ext[AW-2:0];
      endcase
   end
endmodule

// File: rtl/bea_seq.sv
module bea_seq
   import bea_pkg::*;
#(
   parameter int AW = 16
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic           ind,
   input  bmode_e         mode,
   input  logic [AW-2:0]  dir_word,
   input  logic           dir_bsel,
   input  logic [AW-2:0]  ptr_word,
   input  logic [AW-1:0]  xr,
   input  logic [AW-1:0]  rd_data,
   input  logic           rd_valid,
   output logic           rd_req,
   output logic [AW-2:0]  rd_addr,
   output logic [AW-2:0]  ea_word,
   output logic           ea_bsel,
   output logic           done
);
   seq_e          state;
   logic          add_x;
   logic [AW-1:0] x_q;
   logic          last_page0;
   logic [AW-1:0] fin_b;

   assign fin_b = rd_data + (add_x ? x_q : '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         rd_req     <= 1'b0;
         rd_addr    <= '0;
         ea_word    <= '0;
         ea_bsel    <= 1'b0;
         done       <= 1'b0;
         add_x      <= 1'b0;
         x_q        <= '0;
         last_page0 <= 1'b0;
      end else begin
         done <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (start) begin
                  if (!ind) begin
                     ea_word    <= dir_word;
                     ea_bsel    <= dir_bsel;
                     done       <= 1'b1;
                     last_page0 <= (mode == MD_PAGE0);
                  end else begin
                     rd_req     <= 1'b1;
                     rd_addr    <= ptr_word;
                     add_x      <= (mode == MD_INDEX);
                     x_q        <= xr;
                     last_page0 <= 1'b0;
                     state      <= ST_WAIT;
                  end
               end
            end
            default: begin
               if (rd_valid) begin
                  rd_req  <= 1'b0;
                  ea_word <= fin_b[AW-1:1];
                  ea_bsel <= fin_b[0];
                  done    <= 1'b1;
                  state   <= ST_IDLE;
               end
            end
         endcase
      end
   end

   p_reset_quiet_r1: assert property (@(posedge clk)
      !rst_n |=> (!done && !rd_req));

   p_direct_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && start && !ind) |=> (done && !rd_req));

   p_page0_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (done && last_page0) |-> ((ea_word >> 7) == '0));

   p_ind_issue_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && start && ind) |=> (rd_req && !done));

   p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !rd_valid) |=> (rd_req && $stable(rd_addr)));

   p_single_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && rd_valid) |=> (!rd_req && done));

   p_busy_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !rd_valid && start) |=> !done);
endmodule

// File: rtl/bmode_ea_gen.sv
module bmode_ea_gen
   import bea_pkg::*;
#(
   parameter int AW = 16,
   parameter int IW = 16
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic [IW-1:0]  instr,
   input  logic [AW-1:0]  pc,
   input  logic [AW-1:0]  xr,
   input  logic [AW-1:0]  rd_data,
   input  logic           rd_valid,
   output logic           rd_req,
   output logic [AW-2:0]  rd_addr,
   output logic [AW-2:0]  ea_word,
   output logic           ea_bsel,
   output logic           done
);
   localparam int DW      = 8;
   localparam int IND_BIT = DW;
   localparam int MODE_LO = DW + 1;
   localparam int OPC_LO  = MODE_LO + 2;

   generate
      if (IW <= OPC_LO) begin : g_bad_iw
         $error("bmode_ea_gen: IW too small for the field layout");
      end
   endgenerate

   bmode_e        mode;
   logic          ind;
   logic [DW-1:0] disp;
   logic [AW-2:0] dir_word;
   logic          dir_bsel;
   logic [AW-2:0] ptr_word;
   logic          unused_opc;

   assign mode       = bmode_e'(instr[MODE_LO+1:MODE_LO]);
   assign ind        = instr[IND_BIT];
   assign disp       = instr[DW-1:0];
   assign unused_opc = ^instr[IW-1:OPC_LO];

   bea_calc #(.AW(AW), .DW(DW)) calc_i (
      .mode     (mode),
      .disp     (disp),
      .pc       (pc),
      .xr       (xr),
      .dir_word (dir_word),
      .dir_bsel (dir_bsel),
      .ptr_word (ptr_word)
   );

   bea_seq #(.AW(AW)) seq_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .ind      (ind),
      .mode     (mode),
      .dir_word (dir_word),
      .dir_bsel (dir_bsel),
      .ptr_word (ptr_word),
      .xr       (xr),
      .rd_data  (rd_data),
      .rd_valid (rd_valid),
      .rd_req   (rd_req),
      .rd_addr  (rd_addr),
      .ea_word  (ea_word),
      .ea_bsel  (ea_bsel),
      .done     (done)
   );
endmodule

// File: tb/bmode_ea_gen_tb.sv
module bmode_ea_gen_tb_top;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [15:0] instr = '0;
   logic [15:0] pc = '0;
   logic [15:0] xr = '0;
   logic [15:0] rd_data = '0;
   logic        rd_valid = 1'b0;
   logic        rd_req;
   logic [14:0] rd_addr;
   logic [14:0] ea_word;
   logic        ea_bsel;
   logic        done;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   bmode_ea_gen dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .pc(pc), .xr(xr),
      .rd_data(rd_data), .rd_valid(rd_valid), .rd_req(rd_req), .rd_addr(rd_addr),
      .ea_word(ea_word), .ea_bsel(ea_bsel), .done(done)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] mk(input logic [4:0] opc, input logic [1:0] m, input bit i, input logic [7:0] d);
      return {opc, m, i, d};
   endfunction

   // expected {word, bsel} for direct forms
   function automatic logic [15:0] exp_dir(input logic [1:0] m, input logic [7:0] d, input logic [15:0] p, input logic [15:0] x);
      logic [15:0] s;
      case (m)
         2'b00: s = {8'h00, d};
         2'b10: s = x + {8'h00, d};
         2'b01: begin s = p + 16'd1 + {8'h00, d}; s = {s[14:0], 1'b0}; end
         default: begin s = p + 16'd1 + {8'h00, d}; s = {s[14:0], 1'b1}; end
      endcase
      return s;
   endfunction

   function automatic logic [14:0] exp_ptr(input logic [1:0] m, input logic [7:0] d, input logic [15:0] p);
      logic [15:0] s;
      case (m)
         2'b01: s = p + 16'd1 + {8'h00, d};
         2'b11: s = p - {8'h00, d};
         default: s = {8'h00, d};
      endcase
      return s[14:0];
   endfunction

   task automatic run_direct(input logic [4:0] opc, input logic [1:0] m, input logic [7:0] d,
                             input logic [15:0] p, input logic [15:0] x, input string req);
      logic [15:0] e;
      e = exp_dir(m, d, p, x);
      @(negedge clk);
      instr = mk(opc, m, 1'b0, d); pc = p; xr = x; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(done === 1'b1 && rd_req === 1'b0, req, {30'd0, done, rd_req}, 32'h2);
      chk({ea_word, ea_bsel} === e, req, {16'd0, ea_word, ea_bsel}, {16'd0, e});
      @(negedge clk);
      chk(done === 1'b0, req, {31'd0, done}, 32'd0);
   endtask

   task automatic run_ind(input logic [4:0] opc, input logic [1:0] m, input logic [7:0] d,
                          input logic [15:0] p, input logic [15:0] x, input logic [15:0] ptr,
                          input int lat, input string req);
      logic [14:0] pa;
      logic [15:0] b;
      pa = exp_ptr(m, d, p);
      b  = (m == 2'b10) ? ptr + x : ptr;
      @(negedge clk);
      instr = mk(opc, m, 1'b1, d); pc = p; xr = x; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(rd_req === 1'b1 && done === 1'b0, "R5 request", {30'd0, rd_req, done}, 32'h2);
      chk(rd_addr === pa, {req, " R5 pointer address"}, {17'd0, rd_addr}, {17'd0, pa});
      for (int k = 0; k < lat; k++) begin
         // R8: disturb with a fresh start while the read is pending
         instr = mk(5'h1F, ~m, 1'b0, ~d); pc = ~p; xr = ~x; start = (k == 0);
         @(negedge clk);
         start = 1'b0;
         chk(rd_req === 1'b1 && done === 1'b0 && rd_addr === pa, "R8 busy start ignored",
             {rd_req, done, 15'd0, rd_addr}, {2'b10, 15'd0, pa});
      end
      rd_data = ptr; rd_valid = 1'b1;
      @(negedge clk);
      rd_valid = 1'b0; rd_data = 16'hDEAD;
      chk(done === 1'b1 && rd_req === 1'b0, "R7 single read", {30'd0, done, rd_req}, 32'h2);
      chk({ea_word, ea_bsel} === b, {req, " R6 result"}, {16'd0, ea_word, ea_bsel}, {16'd0, b});
      @(negedge clk);
      chk(done === 1'b0 && rd_req === 1'b0, "R7 no second read", {30'd0, done, rd_req}, 32'h0);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 2 + 2);
      chk(done === 1'b0 && rd_req === 1'b0, "R1 reset", {30'd0, done, rd_req}, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(done === 1'b0 && rd_req === 1'b0, "R1 after release", {30'd0, done, rd_req}, 32'd0);

      // direct sweeps over all modes
      for (int m = 0; m < 4; m++) begin
         for (int d = 0; d < 256; d += 17) begin
            string r;
            r = (m == 0) ? "R2 page0" : (m == 2) ? "R4 indexed" : "R3 relative";
            run_direct(5'(d), 2'(m), 8'(d), 16'h1234, 16'h4321, r);
            run_direct(5'(d + 3), 2'(m), 8'(d), 16'h0100 + 16'(d), 16'hA001 + 16'(d * 7), r);
         end
         run_direct(5'h00, 2'(m), 8'hFF, 16'h0040, 16'h00FE, "R2 R3 R4 top displacement");
      end

      // R9 wrap cases
      run_direct(5'h0, 2'b01, 8'h05, 16'h7FFF, 16'h0, "R9 forward wrap word");
      run_direct(5'h0, 2'b11, 8'hFF, 16'hFFFF, 16'h0, "R9 forward wrap 16 bit");
      run_direct(5'h0, 2'b10, 8'h10, 16'h0, 16'hFFF5, "R9 indexed wrap");
      run_ind(5'h0, 2'b11, 8'h05, 16'h0002, 16'h0, 16'h0300, 1, "R9 backward wrap");
      run_ind(5'h0, 2'b10, 8'h01, 16'h0, 16'hFFFF, 16'h0004, 0, "R9 pointer plus index wrap");

      // R10: opcode variation gives identical results
      run_direct(5'h00, 2'b10, 8'h3C, 16'h2000, 16'h0101, "R10 opcode 00");
      run_direct(5'h1F, 2'b10, 8'h3C, 16'h2000, 16'h0101, "R10 opcode 1F");
      run_ind(5'h15, 2'b01, 8'h22, 16'h0500, 16'h0, 16'h1235, 2, "R10 opcode indirect");

      // indirect sweeps over all modes and latencies
      for (int m = 0; m < 4; m++) begin
         for (int d = 0; d < 256; d += 51) begin
            for (int lat = 0; lat < 4; lat++) begin
               run_ind(5'(lat), 2'(m), 8'(d), 16'h3000 + 16'(d), 16'h0203 + 16'(lat * 5),
                       16'h8101 + 16'(d * 3 + lat), lat, "R5 R6 indirect sweep");
            end
         end
      end

      // R7: pointer contents that look like an indirect instruction are still final
      run_ind(5'h0, 2'b00, 8'h10, 16'h0, 16'h0, 16'h0100, 1, "R7 pointer with tag bit");
      run_ind(5'h0, 2'b01, 8'h01, 16'h0010, 16'h0, 16'hFFFF, 0, "R7 all-ones pointer");

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule